// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a processor register file built as a ring of register windows. Each window has three areas: incoming parameters, private locals, and outgoing temporaries. A procedure call makes the next window in the ring the active one, and a return steps back to the previous one. The outgoing area of a window and the incoming area of the next window are the same physical registers. Arguments written by the caller are therefore already in place for the callee, and no data is copied. A bank of globals sits outside the ring and is not affected by calls or returns.

Two pointers manage the ring. `win_cur` selects the active window. `win_saved` marks the boundary of windows that have been moved out to memory. A call that would land on the saved boundary is not performed and raises an overflow trap. A return that would land on it is not performed and raises an underflow trap. An external handler then uses the spill/fill port to copy 16 registers (incoming area plus locals) out of, or back into, the ring. It reports completion with a strobe, and the block moves the saved pointer by one window.

Top module: `win_regfile`

## Requirements
- R1: After reset, `win_cur` is 0, `win_saved` is NWIN-1, both trap outputs are low and every register reads zero.
- R2: Logical register 0 always reads zero, and a write to it is discarded.
- R3: Logical registers 1..7 are globals. They read the same value in every window, across calls and returns.
- R4: A committed call sets `win_cur` to (win_cur+1) mod NWIN. A committed return sets it to (win_cur-1) mod NWIN. Logical registers 16..23 are private to each window, so their values in the caller are seen again after the return.
- R5: Logical registers 24..31 of the caller are the same storage as logical registers 8..15 of the callee, in the same order.
- R6: A read port addressing the register being written in the same cycle returns the write data, with no delay.
- R7: When a call arrives while (win_cur+1) mod NWIN equals `win_saved`, `win_cur` is held, and `ovf_trap` is high for exactly the following cycle.
- R8: When a return arrives, without a call, while (win_cur-1) mod NWIN equals `win_saved`, `win_cur` is held, and `unf_trap` is high for exactly the following cycle.
- R9: `spill_done` sets `win_saved` to (win_saved+1) mod NWIN. `fill_done` without `spill_done` sets it to (win_saved-1) mod NWIN.
- R10: `sf_rdata` returns slot `sf_idx` of window (win_saved+1) mod NWIN. `sf_we` writes `sf_wdata` into slot `sf_idx` of window `win_saved`. Slots 0..7 are the incoming area (logical 8..15) and slots 8..15 are the locals (logical 16..23).
- R11: When `call` and `ret` are asserted together, the call is acted on and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call | input | 1 | Procedure call strobe |
| ret | input | 1 | Procedure return strobe |
| ra_addr | input | 5 | Read port A logical register |
| ra_data | output | DW | Read port A data |
| rb_addr | input | 5 | Read port B logical register |
| rb_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write logical register |
| wr_data | input | DW | Write data |
| win_cur | output | log2(NWIN) | Active window pointer |
| win_saved | output | log2(NWIN) | Saved window boundary pointer |
| ovf_trap | output | 1 | Window overflow pulse |
| unf_trap | output | 1 | Window underflow pulse |
| sf_idx | input | 4 | Spill/fill slot within the window |
| sf_rdata | output | DW | Spill read data |
| sf_we | input | 1 | Fill write enable |
| sf_wdata | input | DW | Fill write data |
| spill_done | input | 1 | Spill finished strobe |
| fill_done | input | 1 | Fill finished strobe |

## Verification
Register traffic is tried first in a single window, then across a call and a return. This tells the globals, the private locals and the shared outgoing/incoming area apart, because only the shared area shows a caller's value under a different logical number. Calls are then run until the ring is full, which checks that the overflow trap fires at the saved boundary, including when the pointer wraps from the last window back to window 0. Returns are run until the trap fires at the other edge of the boundary. Spill reads and fill writes are each followed by a pointer strobe and then a return. The values read back through the ordinary read ports prove that the handler's port reached the right window and slots.

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    call,
  input  logic                    ret,
  input  logic [4:0]              ra_addr,
  output logic [DW-1:0]           ra_data,
  input  logic [4:0]              rb_addr,
  output logic [DW-1:0]           rb_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_addr,
  input  logic [DW-1:0]           wr_data,
  output logic [$clog2(NWIN)-1:0] win_cur,
  output logic [$clog2(NWIN)-1:0] win_saved,
  output logic                    ovf_trap,
  output logic                    unf_trap,
  input  logic [3:0]              sf_idx,
  output logic [DW-1:0]           sf_rdata,
  input  logic                    sf_we,
  input  logic [DW-1:0]           sf_wdata,
  input  logic                    spill_done,
  input  logic                    fill_done
);
  localparam int WPW  = $clog2(NWIN);
  localparam int NREG = 8 + NWIN * 16;
  localparam int PW   = $clog2(NREG);

  function automatic logic [WPW-1:0] wnext(input logic [WPW-1:0] w);
    return (int'(w) == NWIN - 1) ? '0 : w + 1'b1;
  endfunction

  function automatic logic [WPW-1:0] wprev(input logic [WPW-1:0] w);
    return (w == '0) ? WPW'(NWIN - 1) : w - 1'b1;
  endfunction

  function automatic logic [PW-1:0] slot(input logic [WPW-1:0] w, input logic [3:0] s);
    return PW'(8 + int'(w) * 16 + int'(s));
  endfunction

  function automatic logic [PW-1:0] lmap(input logic [4:0] r, input logic [WPW-1:0] w);
    case (r[4:3])
      2'd0:    return PW'(r);
      2'd1:    return slot(w, {1'b0, r[2:0]});
      2'd2:    return slot(w, {1'b1, r[2:0]});
      default: return slot(wnext(w), {1'b0, r[2:0]});
    endcase
  endfunction

  logic [DW-1:0] rf [NREG];
  logic [WPW-1:0] cwp, swp;
  logic [PW-1:0] pa, pb, pw, pf, ps;
  logic ovf_c, unf_c, wr_ok, do_ret;

  assign ovf_c  = (wnext(cwp) == swp);
  assign unf_c  = (wprev(cwp) == swp);
  assign do_ret = ret && !call;
  assign wr_ok  = wr_en && (wr_addr != 5'd0);

  assign pa = lmap(ra_addr, cwp);
  assign pb = lmap(rb_addr, cwp);
  assign pw = lmap(wr_addr, cwp);
  assign pf = slot(swp, sf_idx);
  assign ps = slot(wnext(swp), sf_idx);

  assign ra_data = (ra_addr == 5'd0) ? '0 : (wr_ok && pw == pa) ? wr_data : rf[pa];
  assign rb_data = (rb_addr == 5'd0) ? '0 : (wr_ok && pw == pb) ? wr_data : rf[pb];
  assign sf_rdata = rf[ps];

  assign win_cur   = cwp;
  assign win_saved = swp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp      <= '0;
      swp      <= WPW'(NWIN - 1);
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      ovf_trap <= call && ovf_c;
      unf_trap <= do_ret && unf_c;
      if (call && !ovf_c)
        cwp <= wnext(cwp);
      else if (do_ret && !unf_c)
        cwp <= wprev(cwp);
      if (spill_done)
        swp <= wnext(swp);
      else if (fill_done)
        swp <= wprev(swp);
      if (sf_we)
        rf[pf] <= sf_wdata;
      if (wr_ok)
        rf[pw] <= wr_data;
    end
  end

  // R4
  call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call && !ovf_c) |=> (win_cur == wnext($past(win_cur))));

  // R4
  ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !call && !unf_c) |=> (win_cur == wprev($past(win_cur))));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call && ovf_c) |=> (ovf_trap && $stable(win_cur)));

  // R8
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !call && unf_c) |=> (unf_trap && $stable(win_cur)));

  // R11
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap, unf_trap}));

  // R9
  spill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_done |=> (win_saved == wnext($past(win_saved))));

  // R2
  zero_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == 5'd0) |-> (ra_data == '0));
endmodule

// File: tb/tb_win_regfile.sv
module tb_win_regfile;
  localparam int NWIN = 8;
  localparam int DW   = 32;

  logic clk = 1'b0, rst_n = 1'b0, call = 1'b0, ret = 1'b0;
  logic [4:0] ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic [DW-1:0] ra_data, rb_data, wr_data = '0, sf_rdata, sf_wdata = '0;
  logic wr_en = 1'b0, sf_we = 1'b0, spill_done = 1'b0, fill_done = 1'b0;
  logic [3:0] sf_idx = '0;
  logic [2:0] win_cur, win_saved;
  logic ovf_trap, unf_trap;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  win_regfile #(.NWIN(NWIN), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .call(call), .ret(ret),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_cur(win_cur), .win_saved(win_saved),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap),
    .sf_idx(sf_idx), .sf_rdata(sf_rdata), .sf_we(sf_we), .sf_wdata(sf_wdata),
    .spill_done(spill_done), .fill_done(fill_done));

  // act[75:74] 0 none 1 call 2 ret | wa[73:69] | wd[68:37] | ra[36:32] | exp[31:0]
  localparam logic [75:0] VEC [11] = '{
    {2'd0, 5'd1,  32'h11, 5'd1,  32'h11},
    {2'd0, 5'd9,  32'hA9, 5'd9,  32'hA9},
    {2'd0, 5'd17, 32'hB1, 5'd17, 32'hB1},
    {2'd0, 5'd25, 32'hC1, 5'd25, 32'hC1},
    {2'd1, 5'd0,  32'h0,  5'd9,  32'hC1},
    {2'd0, 5'd0,  32'h0,  5'd17, 32'h0},
    {2'd0, 5'd0,  32'h0,  5'd1,  32'h11},
    {2'd0, 5'd17, 32'hD2, 5'd17, 32'hD2},
    {2'd2, 5'd0,  32'h0,  5'd17, 32'hB1},
    {2'd0, 5'd0,  32'h0,  5'd25, 32'hC1},
    {2'd0, 5'd0,  32'hFF, 5'd0,  32'h0}
  };
  localparam string VREQ [11] = '{"R3", "R4", "R4", "R5", "R5", "R4", "R3", "R4", "R4", "R5", "R2"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) cyc();
    // R1
    check("R1", 32'(win_cur), 32'd0);
    check("R1", 32'(win_saved), 32'd7);
    check("R1", {30'd0, ovf_trap, unf_trap}, 32'd0);
    ra_addr = 5'd9; rb_addr = 5'd20;
    #1;
    check("R1", ra_data, 32'd0);
    check("R1", rb_data, 32'd0);
    rst_n = 1'b1;
    cyc();

    for (int i = 0; i < 11; i++) begin
      call = (VEC[i][75:74] == 2'd1);
      ret  = (VEC[i][75:74] == 2'd2);
      wr_addr = VEC[i][73:69];
      wr_data = VEC[i][68:37];
      wr_en = (VEC[i][73:69] != 5'd0) || (VEC[i][68:37] != 32'd0);
      cyc();
      call = 1'b0; ret = 1'b0; wr_en = 1'b0;
      ra_addr = VEC[i][36:32];
      #1;
      check(VREQ[i], ra_data, VEC[i][31:0]);
    end

    // R6 forwarding on both ports
    wr_en = 1'b1; wr_addr = 5'd18; wr_data = 32'h55;
    ra_addr = 5'd18; rb_addr = 5'd18;
    #1;
    check("R6", ra_data, 32'h55);
    check("R6", rb_data, 32'h55);
    cyc();
    wr_en = 1'b0;

    // R11 call wins over ret
    call = 1'b1; ret = 1'b1;
    cyc();
    call = 1'b0; ret = 1'b0;
    check("R11", 32'(win_cur), 32'd1);

    repeat (5) begin
      call = 1'b1; cyc();
    end
    call = 1'b0;
    check("R4", 32'(win_cur), 32'd6);

    // R7 overflow at window 6 with saved boundary 7
    call = 1'b1;
    cyc();
    call = 1'b0;
    check("R7", 32'(win_cur), 32'd6);
    check("R7", 32'(ovf_trap), 32'd1);
    cyc();
    check("R7", 32'(ovf_trap), 32'd0);

    // R10 spill reads window 0: slot 1 = logical 9, slot 9 = logical 17
    sf_idx = 4'd1; #1;
    check("R10", sf_rdata, 32'hA9);
    sf_idx = 4'd9; #1;
    check("R10", sf_rdata, 32'hB1);
    spill_done = 1'b1;
    cyc();
    spill_done = 1'b0;
    check("R9", 32'(win_saved), 32'd0);

    call = 1'b1; cyc(); call = 1'b0;
    check("R4", 32'(win_cur), 32'd7);
    check("R7", 32'(ovf_trap), 32'd0);
    call = 1'b1; cyc(); call = 1'b0;
    check("R7", 32'(win_cur), 32'd7);
    check("R7", 32'(ovf_trap), 32'd1);
    cyc();

    repeat (6) begin
      ret = 1'b1; cyc();
    end
    ret = 1'b0;
    check("R4", 32'(win_cur), 32'd1);
    check("R8", 32'(unf_trap), 32'd0);

    // R8 underflow at window 1 with saved boundary 0
    ret = 1'b1;
    cyc();
    ret = 1'b0;
    check("R8", 32'(win_cur), 32'd1);
    check("R8", 32'(unf_trap), 32'd1);
    cyc();
    check("R8", 32'(unf_trap), 32'd0);

    // R10 fill window 0
    sf_we = 1'b1; sf_idx = 4'd1; sf_wdata = 32'h77;
    cyc();
    sf_idx = 4'd9; sf_wdata = 32'h88;
    cyc();
    sf_we = 1'b0;
    fill_done = 1'b1;
    cyc();
    fill_done = 1'b0;
    check("R9", 32'(win_saved), 32'd7);

    ret = 1'b1; cyc(); ret = 1'b0;
    check("R4", 32'(win_cur), 32'd0);
    ra_addr = 5'd9; rb_addr = 5'd17;
    #1;
    check("R10", ra_data, 32'h77);
    check("R10", rb_data, 32'h88);

    // R8 wrap: return at window 0 with saved boundary 7
    ret = 1'b1;
    cyc();
    ret = 1'b0;
    check("R8", 32'(win_cur), 32'd0);
    check("R8", 32'(unf_trap), 32'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule